// File: doc/BRIEF.md
# Victim Line Write-Back Buffer

This block parks dirty cache lines that the processor evicts until the memory sequencer has time to write them to DRAM. It has two line slots. Each slot holds a line address and a 64-byte payload, and the payload moves as four 128-bit beats. The capture port loads one whole line in one cycle. The write-back port presents the oldest held line one beat at a time, with a request that the arbiter treats as low priority. That request is raised to urgent while both slots are taken, so that a slot is freed before a third victim arrives.

Every fill, DMA read or DMA write address is presented on the snoop port. It is compared at line granularity against the valid slots. On a hit, the block copies the matching line into a read-out register and streams it as four beats on the read-out port, so the requester takes the line or its merge data from the buffer instead of from DRAM.

The slots are tracked by an occupancy state machine with three states:

- `OCC_EMPTY`: no slot is taken.
- `OCC_ONE`: one slot is taken.
- `OCC_TWO`: both slots are taken.

Its transitions are:

- capture: `OCC_EMPTY` to `OCC_ONE`, and `OCC_ONE` to `OCC_TWO`.
- retire: `OCC_TWO` to `OCC_ONE`, and `OCC_ONE` to `OCC_EMPTY`.
- capture plus retire in the same cycle: `OCC_ONE` stays in `OCC_ONE`.

The read-out state machine has two states:

- `RD_IDLE`: no line is being streamed.
- `RD_SEND`: a line is being streamed.

Its transitions are:

- launch: `RD_IDLE` to `RD_SEND`.
- last beat with no new launch: `RD_SEND` to `RD_IDLE`.
- last beat with a new launch: `RD_SEND` stays in `RD_SEND`, which gives back-to-back read-outs.

Top module: `victim_buf`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `wb_req`, `wb_urgent`, `vic_full`, `snp_hit` (with `snp_valid` low) and `rd_valid` are all 0.
- R2: A `vic_load` pulse taken while `vic_full` is 0 stores the line. From the next cycle, `wb_req` is 1 while any line is held, and it is 0 when none is held.
- R3: `vic_full` is 1 exactly while two lines are held. A `vic_load` seen while `vic_full` is 1 is ignored, even if a retirement completes in that same cycle.
- R4: `wb_urgent` is 1 exactly while two lines are held. It is 0 while only one line is held.
- R5: While `wb_req` is 1, `wb_addr` is the address of the oldest held line. `wb_data` is beat `wb_beat` of that line, where beat i is line bits [128*i+127:128*i]. `wb_beat` starts at 0 and advances by one on each cycle with `wb_ready` high. It holds while `wb_ready` is low.
- R6: A line is retired on the cycle its beat 3 is accepted. Lines retire in capture order, and the next cycle presents the following line from beat 0.
- R7: When one line is held, a capture and the retirement of that line in the same cycle leave exactly the new line held, with `wb_urgent` at 0.
- R8: `snp_hit` is 1 in the same cycle that `snp_valid` is 1 and bits [AW-1:6] of `snp_addr` equal those of a held line's address. The low six bits are ignored, and lines not held never match.
- R9: A launched snoop hit produces `rd_valid` for the four following cycles, with `rd_beat` 0,1,2,3 and `rd_data` the corresponding beats of the matching line. `rd_kind` repeats the launching `snp_kind`, which is 0 for a fill, 1 for a DMA read and 2 for a DMA write merge.
- R10: A hit launches a read-out only when no read-out is running, or in the cycle the running one shows beat 3. A hit at any other time leaves the running read-out undisturbed.
- R11: When both held lines match the snoop address, the read-out streams the older line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| vic_load | input | 1 | Capture a victim line this cycle |
| vic_addr | input | AW | Address of the victim line |
| vic_line | input | 4*BEAT_W | Victim payload, beat i in bits [BEAT_W*i+BEAT_W-1:BEAT_W*i] |
| vic_full | output | 1 | Both slots taken; captures are ignored |
| wb_req | output | 1 | A held line waits for write-back |
| wb_urgent | output | 1 | Write-back must win arbitration now |
| wb_ready | input | 1 | The current write-back beat is accepted |
| wb_addr | output | AW | Address of the oldest held line |
| wb_data | output | BEAT_W | Current write-back beat |
| wb_beat | output | 2 | Index of the current write-back beat |
| snp_valid | input | 1 | Snoop address is valid |
| snp_kind | input | 2 | Requester type: 0 fill, 1 DMA read, 2 DMA write merge |
| snp_addr | input | AW | Fill or DMA address to compare |
| snp_hit | output | 1 | Snoop address matches a held line |
| rd_valid | output | 1 | A read-out beat is presented |
| rd_beat | output | 2 | Index of the read-out beat |
| rd_data | output | BEAT_W | Read-out beat from the buffer |
| rd_kind | output | 2 | Requester type of the running read-out |

## Verification
The results of this block fall due at different times:

- `snp_hit` is combinational and is due in the same cycle as the snoop.
- `wb_req`, `wb_urgent` and `vic_full` change one cycle after the capturing or retiring edge.
- The first read-out beat is due one cycle after the launching hit, and the later beats follow on consecutive cycles.

The bench drives every input on the falling edge and samples all outputs 1 ns later. It compares them with a queue-based model whose state reflects every rising edge so far. The model applies the coming edge only after the comparison, so each output is checked in exactly the cycle it becomes due.

// File: rtl/vb_pkg.sv
package vb_pkg;
    localparam int NUM_ENT = 2;

    typedef enum logic [1:0] {
        OCC_EMPTY = 2'd0,
        OCC_ONE   = 2'd1,
        OCC_TWO   = 2'd2
    } occ_e;

    typedef enum logic {
        RD_IDLE = 1'b0,
        RD_SEND = 1'b1
    } rd_e;
endpackage

// File: rtl/vb_store.sv
module vb_store
    import vb_pkg::*;
#(
    parameter int AW     = 34,
    parameter int BEAT_W = 128,
    parameter int BEATS  = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load_i,
    input  logic [AW-1:0]                 load_addr_i,
    input  logic [BEAT_W*BEATS-1:0]       load_line_i,
    input  logic                          wb_ready_i,
    output logic                          full_o,
    output logic                          wb_req_o,
    output logic                          wb_urgent_o,
    output logic [AW-1:0]                 wb_addr_o,
    output logic [BEAT_W-1:0]             wb_data_o,
    output logic [$clog2(BEATS)-1:0]      wb_beat_o,
    output logic                          head_o,
    output logic [NUM_ENT-1:0]            ent_valid_o,
    output logic [NUM_ENT-1:0][AW-1:0]    ent_addr_o,
    output logic [NUM_ENT-1:0][BEAT_W*BEATS-1:0] ent_line_o
);
    localparam int LINE_W = BEAT_W * BEATS;
    localparam int BW     = $clog2(BEATS);
    localparam logic [BW-1:0] LAST = BW'(BEATS - 1);

    occ_e                occ_q, occ_n;
    logic                head_q;
    logic [NUM_ENT-1:0]  vld_q;
    logic [BW-1:0]       beat_q;
    logic [AW-1:0]       addr_q [NUM_ENT];
    logic [LINE_W-1:0]   line_q [NUM_ENT];
    logic                load_ok;
    logic                retire;
    logic                slot;

    // output decode of the occupancy state
    always_comb begin
        wb_req_o    = 1'b0;
        wb_urgent_o = 1'b0;
        unique case (occ_q)
            OCC_EMPTY: begin
                wb_req_o    = 1'b0;
                wb_urgent_o = 1'b0;
            end
            OCC_ONE: begin
                wb_req_o    = 1'b1;
                wb_urgent_o = 1'b0;
            end
            OCC_TWO: begin
                wb_req_o    = 1'b1;
                wb_urgent_o = 1'b1;
            end
            default: begin
                wb_req_o    = 1'b0;
                wb_urgent_o = 1'b0;
            end
        endcase
    end

    assign full_o  = wb_urgent_o;
    assign load_ok = load_i && !full_o;
    assign retire  = wb_req_o && wb_ready_i && (beat_q == LAST);
    assign slot    = (occ_q == OCC_EMPTY) ? head_q : ~head_q;

    // next occupancy state
    always_comb begin
        occ_n = occ_q;
        unique case (occ_q)
            OCC_EMPTY: if (load_ok) occ_n = OCC_ONE;
            OCC_ONE: begin
                if (load_ok && !retire)      occ_n = OCC_TWO;
                else if (!load_ok && retire) occ_n = OCC_EMPTY;
                else                         occ_n = OCC_ONE;
            end
            OCC_TWO:   if (retire) occ_n = OCC_ONE;
            default:   occ_n = OCC_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            occ_q  <= OCC_EMPTY;
            head_q <= 1'b0;
            vld_q  <= '0;
            beat_q <= '0;
        end else begin
            occ_q <= occ_n;
            if (retire) begin
                head_q        <= ~head_q;
                vld_q[head_q] <= 1'b0;
            end
            if (load_ok)
                vld_q[slot] <= 1'b1;
            if (wb_req_o && wb_ready_i)
                beat_q <= (beat_q == LAST) ? '0 : beat_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (load_ok) begin
            addr_q[slot] <= load_addr_i;
            line_q[slot] <= load_line_i;
        end
    end

    assign wb_addr_o   = addr_q[head_q];
    assign wb_data_o   = line_q[head_q][beat_q*BEAT_W +: BEAT_W];
    assign wb_beat_o   = beat_q;
    assign head_o      = head_q;
    assign ent_valid_o = vld_q;

    for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
        assign ent_addr_o[g] = addr_q[g];
        assign ent_line_o[g] = line_q[g];
    end
endmodule

// File: rtl/vb_match.sv
module vb_match
    import vb_pkg::*;
#(
    parameter int AW  = 34,
    parameter int OFS = 6
) (
    input  logic                       probe_valid_i,
    input  logic [AW-1:0]              probe_addr_i,
    input  logic                       head_i,
    input  logic [NUM_ENT-1:0]         ent_valid_i,
    input  logic [NUM_ENT-1:0][AW-1:0] ent_addr_i,
    output logic                       hit_o,
    output logic                       sel_o
);
    logic [NUM_ENT-1:0] raw;

    for (genvar g = 0; g < NUM_ENT; g++) begin : g_cmp
        assign raw[g] = ent_valid_i[g] &&
                        (ent_addr_i[g][AW-1:OFS] == probe_addr_i[AW-1:OFS]);
    end

    assign hit_o = probe_valid_i && (|raw);
    // the older slot wins when both match
    assign sel_o = raw[head_i] ? head_i : ~head_i;
endmodule

// File: rtl/vb_readout.sv
module vb_readout
    import vb_pkg::*;
#(
    parameter int BEAT_W = 128,
    parameter int BEATS  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic [BEAT_W*BEATS-1:0]  line_i,
    input  logic [1:0]               kind_i,
    output logic                     rd_valid_o,
    output logic [$clog2(BEATS)-1:0] rd_beat_o,
    output logic [BEAT_W-1:0]        rd_data_o,
    output logic [1:0]               rd_kind_o
);
    localparam int LINE_W = BEAT_W * BEATS;
    localparam int BW     = $clog2(BEATS);
    localparam logic [BW-1:0] LAST = BW'(BEATS - 1);

    rd_e               st_q, st_n;
    logic [BW-1:0]     beat_q;
    logic [LINE_W-1:0] line_q;
    logic [1:0]        kind_q;
    logic              launch;

    assign launch = start_i && ((st_q == RD_IDLE) || (beat_q == LAST));

    always_comb begin
        st_n = st_q;
        unique case (st_q)
            RD_IDLE: st_n = launch ? RD_SEND : RD_IDLE;
            RD_SEND: begin
                if (beat_q == LAST) st_n = launch ? RD_SEND : RD_IDLE;
                else                st_n = RD_SEND;
            end
            default: st_n = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= RD_IDLE;
            beat_q <= '0;
        end else begin
            st_q <= st_n;
            if (launch)                beat_q <= '0;
            else if (st_q == RD_SEND)  beat_q <= beat_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (launch) begin
            line_q <= line_i;
            kind_q <= kind_i;
        end
    end

    always_comb begin
        rd_valid_o = 1'b0;
        unique case (st_q)
            RD_IDLE: rd_valid_o = 1'b0;
            RD_SEND: rd_valid_o = 1'b1;
            default: rd_valid_o = 1'b0;
        endcase
    end

    assign rd_beat_o = beat_q;
    assign rd_data_o = line_q[beat_q*BEAT_W +: BEAT_W];
    assign rd_kind_o = kind_q;
endmodule

// File: rtl/victim_buf.sv
module victim_buf
    import vb_pkg::*;
#(
    parameter int AW     = 34,
    parameter int BEAT_W = 128,
    parameter int BEATS  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     vic_load,
    input  logic [AW-1:0]            vic_addr,
    input  logic [BEAT_W*BEATS-1:0]  vic_line,
    output logic                     vic_full,
    output logic                     wb_req,
    output logic                     wb_urgent,
    input  logic                     wb_ready,
    output logic [AW-1:0]            wb_addr,
    output logic [BEAT_W-1:0]        wb_data,
    output logic [$clog2(BEATS)-1:0] wb_beat,
    input  logic                     snp_valid,
    input  logic [1:0]               snp_kind,
    input  logic [AW-1:0]            snp_addr,
    output logic                     snp_hit,
    output logic                     rd_valid,
    output logic [$clog2(BEATS)-1:0] rd_beat,
    output logic [BEAT_W-1:0]        rd_data,
    output logic [1:0]               rd_kind
);
    localparam int LINE_W = BEAT_W * BEATS;
    localparam int OFS    = $clog2(LINE_W / 8);

    logic                       head;
    logic                       sel;
    logic [NUM_ENT-1:0]         ent_valid;
    logic [NUM_ENT-1:0][AW-1:0] ent_addr;
    logic [NUM_ENT-1:0][LINE_W-1:0] ent_line;

    vb_store #(.AW(AW), .BEAT_W(BEAT_W), .BEATS(BEATS)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (vic_load),
        .load_addr_i (vic_addr),
        .load_line_i (vic_line),
        .wb_ready_i  (wb_ready),
        .full_o      (vic_full),
        .wb_req_o    (wb_req),
        .wb_urgent_o (wb_urgent),
        .wb_addr_o   (wb_addr),
        .wb_data_o   (wb_data),
        .wb_beat_o   (wb_beat),
        .head_o      (head),
        .ent_valid_o (ent_valid),
        .ent_addr_o  (ent_addr),
        .ent_line_o  (ent_line)
    );

    vb_match #(.AW(AW), .OFS(OFS)) u_match (
        .probe_valid_i (snp_valid),
        .probe_addr_i  (snp_addr),
        .head_i        (head),
        .ent_valid_i   (ent_valid),
        .ent_addr_i    (ent_addr),
        .hit_o         (snp_hit),
        .sel_o         (sel)
    );

    vb_readout #(.BEAT_W(BEAT_W), .BEATS(BEATS)) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (snp_hit),
        .line_i     (ent_line[sel]),
        .kind_i     (snp_kind),
        .rd_valid_o (rd_valid),
        .rd_beat_o  (rd_beat),
        .rd_data_o  (rd_data),
        .rd_kind_o  (rd_kind)
    );
endmodule

// File: rtl/victim_buf_chk.sv
module victim_buf_chk #(
    parameter int AW    = 34,
    parameter int BEATS = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     vic_load,
    input logic                     vic_full,
    input logic                     wb_req,
    input logic                     wb_urgent,
    input logic                     wb_ready,
    input logic [AW-1:0]            wb_addr,
    input logic [$clog2(BEATS)-1:0] wb_beat,
    input logic                     snp_hit,
    input logic                     rd_valid,
    input logic [$clog2(BEATS)-1:0] rd_beat
);
    localparam int BW = $clog2(BEATS);
    localparam logic [BW-1:0] LAST = BW'(BEATS - 1);

    p_urgent_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wb_urgent |-> wb_req);

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        vic_full && !(wb_ready && wb_beat == LAST) |=> vic_full);

    p_stay_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wb_req && !vic_load |=> !wb_req);

    p_beat_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req && !wb_ready |=> $stable(wb_beat) && $stable(wb_addr));

    p_beat_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req && wb_ready && wb_beat != LAST |=> wb_beat == $past(wb_beat) + 1'b1);

    p_retire_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req && wb_ready && wb_beat == LAST |=> wb_beat == '0);

    p_rd_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        snp_hit && !rd_valid |=> rd_valid && rd_beat == '0);

    p_rd_run_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && rd_beat != LAST |=> rd_valid && rd_beat == $past(rd_beat) + 1'b1);
endmodule

bind victim_buf victim_buf_chk #(.AW(AW), .BEATS(BEATS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .vic_load  (vic_load),
    .vic_full  (vic_full),
    .wb_req    (wb_req),
    .wb_urgent (wb_urgent),
    .wb_ready  (wb_ready),
    .wb_addr   (wb_addr),
    .wb_beat   (wb_beat),
    .snp_hit   (snp_hit),
    .rd_valid  (rd_valid),
    .rd_beat   (rd_beat)
);

// File: tb/victim_buf_tb.sv
`timescale 1ns/1ps
module victim_buf_tb;
    localparam int AW = 34;
    localparam int BW128 = 128;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vic_load = 1'b0;
    logic [AW-1:0] vic_addr = '0;
    logic [511:0] vic_line = '0;
    logic vic_full, wb_req, wb_urgent;
    logic wb_ready = 1'b0;
    logic [AW-1:0] wb_addr;
    logic [127:0] wb_data;
    logic [1:0] wb_beat;
    logic snp_valid = 1'b0;
    logic [1:0] snp_kind = '0;
    logic [AW-1:0] snp_addr = '0;
    logic snp_hit, rd_valid;
    logic [1:0] rd_beat, rd_kind;
    logic [127:0] rd_data;

    victim_buf u_dut (
        .clk(clk), .rst_n(rst_n), .vic_load(vic_load), .vic_addr(vic_addr),
        .vic_line(vic_line), .vic_full(vic_full), .wb_req(wb_req),
        .wb_urgent(wb_urgent), .wb_ready(wb_ready), .wb_addr(wb_addr),
        .wb_data(wb_data), .wb_beat(wb_beat), .snp_valid(snp_valid),
        .snp_kind(snp_kind), .snp_addr(snp_addr), .snp_hit(snp_hit),
        .rd_valid(rd_valid), .rd_beat(rd_beat), .rd_data(rd_data),
        .rd_kind(rd_kind)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    string phase = "R1";

    typedef struct {
        logic [AW-1:0] a;
        logic [511:0]  d;
    } ent_t;
    ent_t q[$];
    int wbb = 0;
    bit rd_act = 1'b0;
    int rd_b = 0;
    logic [511:0] rd_line = '0;
    logic [1:0] rd_k = '0;

    task automatic chk(input string r, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s (phase %s) %s actual=%0h expected=%0h", r, phase, what, act, exp);
        end
    endtask

    function automatic logic [511:0] mkline();
        logic [511:0] l;
        for (int i = 0; i < 16; i++) l[i*32 +: 32] = $urandom;
        return l;
    endfunction

    function automatic logic [AW-1:0] lad(input int idx, input int low);
        return 34'h2_0000_0000 + 34'(idx * 64) + 34'(low & 63);
    endfunction

    // one clock: drive at falling edge, compare 1 ns later, then advance the model
    task automatic step(input bit ld, input logic [AW-1:0] la, input logic [511:0] ll,
                        input bit rdy, input bit sv, input logic [1:0] sk,
                        input logic [AW-1:0] sa);
        int hidx;
        bit hit, full_b, req;
        @(negedge clk);
        vic_load = ld; vic_addr = la; vic_line = ll; wb_ready = rdy;
        snp_valid = sv; snp_kind = sk; snp_addr = sa;
        #1;
        req = (q.size() > 0);
        full_b = (q.size() == 2);
        hidx = -1;
        for (int i = q.size() - 1; i >= 0; i--)
            if (q[i].a[AW-1:6] == sa[AW-1:6]) hidx = i;
        hit = sv && (hidx >= 0);
        chk("R2", "wb_req", 128'(wb_req), 128'(req));
        chk("R4", "wb_urgent", 128'(wb_urgent), 128'(full_b));
        chk("R3", "vic_full", 128'(vic_full), 128'(full_b));
        if (req) begin
            chk("R5", "wb_addr", 128'(wb_addr), 128'(q[0].a));
            chk("R5", "wb_beat", 128'(wb_beat), 128'(wbb));
            chk("R5", "wb_data", wb_data, q[0].d[wbb*BW128 +: BW128]);
        end
        chk("R8", "snp_hit", 128'(snp_hit), 128'(hit));
        chk("R9", "rd_valid", 128'(rd_valid), 128'(rd_act));
        if (rd_act) begin
            chk("R9", "rd_beat", 128'(rd_beat), 128'(rd_b));
            chk("R9", "rd_kind", 128'(rd_kind), 128'(rd_k));
            chk("R9", "rd_data", rd_data, rd_line[rd_b*BW128 +: BW128]);
        end
        if (hit && (!rd_act || rd_b == 3)) begin
            rd_act = 1'b1; rd_b = 0; rd_line = q[hidx].d; rd_k = sk;
        end else if (rd_act) begin
            if (rd_b == 3) rd_act = 1'b0;
            else rd_b++;
        end
        if (req && rdy) begin
            if (wb_b_last()) begin
                void'(q.pop_front());
                wbb = 0;
            end else wbb++;
        end
        if (ld && !full_b) q.push_back('{a: la, d: ll});
    endtask

    function automatic bit wb_b_last();
        return wbb == 3;
    endfunction

    task automatic idle(input int n, input bit rdy);
        for (int i = 0; i < n; i++) step(0, '0, '0, rdy, 0, 2'd0, '0);
    endtask

    task automatic load(input logic [AW-1:0] a, input bit rdy);
        step(1, a, mkline(), rdy, 0, 2'd0, '0);
    endtask

    task automatic snoop(input logic [AW-1:0] a, input logic [1:0] k);
        step(0, '0, '0, 0, 1, k, a);
    endtask

    initial begin
        // R1: outputs during and right after reset
        phase = "R1";
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); #1;
            chk("R1", "wb_req", 128'(wb_req), 128'd0);
            chk("R1", "wb_urgent", 128'(wb_urgent), 128'd0);
            chk("R1", "vic_full", 128'(vic_full), 128'd0);
            chk("R1", "rd_valid", 128'(rd_valid), 128'd0);
        end
        rst_n = 1'b1;
        idle(1, 0);

        phase = "R2";
        load(lad(1, 5), 0);
        idle(3, 0);
        phase = "R5";
        idle(2, 1);
        idle(2, 0);
        idle(2, 1);
        idle(1, 0);

        phase = "R3";
        load(lad(2, 0), 0);
        load(lad(3, 9), 0);
        load(lad(4, 0), 0);
        phase = "R4";
        idle(2, 0);

        phase = "R6";
        idle(9, 1);
        idle(1, 0);

        phase = "R7";
        load(lad(5, 1), 0);
        idle(3, 1);
        load(lad(6, 2), 1);
        idle(2, 0);

        phase = "R8";
        snoop(lad(6, 63), 2'd0);
        idle(4, 0);
        snoop(lad(7, 0), 2'd1);
        snoop(lad(5, 1), 2'd1);
        idle(2, 0);

        phase = "R10";
        load(lad(8, 3), 0);
        snoop(lad(6, 0), 2'd2);
        snoop(lad(8, 0), 2'd1);
        idle(2, 0);
        snoop(lad(8, 7), 2'd1);
        idle(5, 0);

        phase = "R11";
        idle(9, 1);
        load(lad(9, 4), 0);
        load(lad(9, 40), 0);
        snoop(lad(9, 0), 2'd0);
        idle(5, 0);
        idle(9, 1);

        phase = "mix";
        for (int c = 0; c < 3000; c++) begin
            step(($urandom % 4) == 0, lad($urandom % 4, $urandom), mkline(),
                 ($urandom % 2) == 1, ($urandom % 3) == 0, 2'($urandom % 3),
                 lad($urandom % 4, $urandom));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule